// File: doc/BRIEF.md
# Overlay Window Scanout Address Generator

This block produces the read addresses that fetch one overlay window from memory while the display is scanning out. The window is a rectangle cut from a wider framebuffer. Each line is read only across its visible width, and the block then jumps over the bytes of the framebuffer line that lie outside the window. Reads are issued as bursts over a simple request/grant handshake. A request holds its address and length until it is granted. A pulse at the start of each frame makes the block begin again at the first byte of the window.

Software prepares five values before the frame. The first byte of the window is the framebuffer base plus the y offset times the line pitch plus the x offset times the bytes per pixel. The visible line size in bytes is the visible width times the bytes per pixel. The per-line skip is the unused part of each framebuffer line, in bytes. The end address is the first byte plus the framebuffer width times the window height times the bytes per pixel. The last value is a pixel format code that sets the burst size. The block captures all of them when the frame starts. It raises a done flag as soon as the next read would land at or past the end address.

Top module: `ovl_scan_addr`

## Requirements
- R1: After reset, `req`, `done`, `req_addr` and `cur_line` are all zero.
- R2: The clock edge that samples `frame_start` high loads `req_addr` with `cfg_start_addr`, clears `cur_line` and `done`, and raises `req`. This applies when the configuration is non-empty (see R9).
- R3: The burst size follows `cfg_pix_fmt`, with words of 4 bytes. Code 0 (8-bit palette) gives 8 words (32 bytes). Codes 1 and 2 (16-bit) give 16 words (64 bytes), and so do codes 3 and 4 (32-bit). Any other code (5 to 7) falls back to unpacked 24-bit handling with 16-word (64-byte) bursts.
- R4: `req_len` is the smaller of the burst size and the bytes still unread in the current line, so the last burst of a line can be shorter.
- R5: When a burst is granted and the line is not yet complete, the next `req_addr` is the granted address plus the granted length.
- R6: When a granted burst completes a line, the next `req_addr` is the granted address plus the granted length plus the per-line skip, and `cur_line` increments by one.
- R7: While `req` is high and `gnt` is low, `req`, `req_addr` and `req_len` stay unchanged.
- R8: If the address after a granted burst is at or beyond the end address, `req` drops and `done` rises on that edge. `done` then stays high, and `gnt` has no effect, until the next `frame_start`.
- R9: If the frame starts with a line size of zero, or with a start address not below the end address, `done` rises at once and no request is made.
- R10: The configuration inputs are captured on `frame_start`. Changing them during the frame does not alter the addresses or lengths of that frame.
- R11: A `frame_start` in the middle of a frame abandons it and restarts at the start address with `cur_line` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that begins a new frame |
| cfg_start_addr | input | AW | Address of the first visible byte of the window |
| cfg_end_addr | input | AW | Address at or beyond which the frame is complete |
| cfg_line_bytes | input | LW | Visible bytes per line |
| cfg_skip_bytes | input | LW | Bytes skipped after each visible line |
| cfg_pix_fmt | input | 3 | Pixel format code that selects the burst size |
| gnt | input | 1 | Grant for the pending request |
| req | output | 1 | Burst read request |
| req_addr | output | AW | Byte address of the requested burst |
| req_len | output | LW | Length in bytes of the requested burst |
| done | output | 1 | Window fully requested for this frame |
| cur_line | output | LCW | Index of the line being fetched |

## Verification
The bench runs windows whose visible width is not a multiple of the burst. A design that ignored the remaining line length would read past the window edge into the skipped region. Windows with a zero skip and windows with a nonzero skip are both covered, so a design that applied the skip after every burst, or never applied it, gives wrong addresses after the first burst. Every format code is used, including the three unknown codes; a wrong fallback shows up as a 32-byte first burst. The bench also covers a grant held back for several cycles, a grant after done, a restart mid-frame, configuration changed mid-frame, and empty windows. In these cases a faulty design would move its address without a grant, keep requesting past the end, or mix old and new geometry in one frame.

// File: rtl/ovl_scan_pkg.sv
package ovl_scan_pkg;

  // Pixel format codes seen on cfg_pix_fmt
  localparam logic [2:0] FMT_PAL8    = 3'd0;
  localparam logic [2:0] FMT_RGB1555 = 3'd1;
  localparam logic [2:0] FMT_RGB565  = 3'd2;
  localparam logic [2:0] FMT_XRGB32  = 3'd3;
  localparam logic [2:0] FMT_ARGB32  = 3'd4;

  typedef enum logic [1:0] {
    CLS_PAL8,
    CLS_HALF,
    CLS_WORD,
    CLS_FALLBACK
  } fmt_class_e;

  function automatic fmt_class_e classify_fmt(input logic [2:0] code);
    case (code)
      FMT_PAL8:               classify_fmt = CLS_PAL8;
      FMT_RGB1555, FMT_RGB565: classify_fmt = CLS_HALF;
      FMT_XRGB32, FMT_ARGB32:  classify_fmt = CLS_WORD;
      default:                classify_fmt = CLS_FALLBACK;
    endcase
  endfunction

endpackage

// File: rtl/ovl_burst_sel.sv
module ovl_burst_sel
  import ovl_scan_pkg::*;
#(
  parameter int LW          = 16,
  parameter int WORD_BYTES  = 4,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 16
) (
  input  logic [2:0]    fmt,
  output logic [LW-1:0] burst_bytes
);
  localparam logic [LW-1:0] SHORT_B = LW'(SHORT_WORDS * WORD_BYTES);
  localparam logic [LW-1:0] LONG_B  = LW'(LONG_WORDS * WORD_BYTES);

  fmt_class_e cls;

  always_comb begin
    cls = classify_fmt(fmt);
    case (cls)
      CLS_PAL8: burst_bytes = SHORT_B;
      default:  burst_bytes = LONG_B;
    endcase
  end
endmodule

// File: rtl/ovl_chunk_len.sv
module ovl_chunk_len #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] remain,
  input  logic [LW-1:0] burst,
  output logic [LW-1:0] len
);
  always_comb len = (remain < burst) ? remain : burst;
endmodule

// File: rtl/ovl_line_walker.sv
module ovl_line_walker #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int LCW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic           gnt,
  input  logic [AW-1:0]  cfg_start,
  input  logic [AW-1:0]  cfg_end,
  input  logic [LW-1:0]  cfg_line,
  input  logic [LW-1:0]  cfg_skip,
  input  logic [LW-1:0]  burst_in,
  output logic           req,
  output logic [AW-1:0]  req_addr,
  output logic [LW-1:0]  req_len,
  output logic           done,
  output logic [LCW-1:0] cur_line
);
  // Frame-captured configuration
  logic [AW-1:0] end_q;
  logic [LW-1:0] line_q;
  logic [LW-1:0] skip_q;
  logic [LW-1:0] burst_q;
  logic [LW-1:0] pos_q;

  logic          seg_end;
  logic [AW-1:0] step;
  logic [AW:0]   nxt_addr_w;
  logic          nxt_done;
  logic [LW-1:0] nxt_pos;
  logic [LW-1:0] nxt_remain;
  logic [LW-1:0] nxt_len;
  logic [LW-1:0] first_len;
  logic          start_empty;

  always_comb begin
    seg_end    = ({1'b0, pos_q} + {1'b0, req_len}) >= {1'b0, line_q};
    step       = seg_end ? (AW'(req_len) + AW'(skip_q)) : AW'(req_len);
    nxt_addr_w = {1'b0, req_addr} + {1'b0, step};
    nxt_done   = nxt_addr_w >= {1'b0, end_q};
    nxt_pos    = seg_end ? '0 : (pos_q + req_len);
    nxt_remain = line_q - nxt_pos;
    start_empty = (cfg_line == '0) || (cfg_start >= cfg_end);
  end

  ovl_chunk_len #(.LW(LW)) u_next_chunk (
    .remain (nxt_remain),
    .burst  (burst_q),
    .len    (nxt_len)
  );

  ovl_chunk_len #(.LW(LW)) u_first_chunk (
    .remain (cfg_line),
    .burst  (burst_in),
    .len    (first_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q    <= '0;
      line_q   <= '0;
      skip_q   <= '0;
      burst_q  <= '0;
      pos_q    <= '0;
      req      <= 1'b0;
      req_addr <= '0;
      req_len  <= '0;
      done     <= 1'b0;
      cur_line <= '0;
    end else if (frame_start) begin
      end_q    <= cfg_end;
      line_q   <= cfg_line;
      skip_q   <= cfg_skip;
      burst_q  <= burst_in;
      pos_q    <= '0;
      req_addr <= cfg_start;
      req_len  <= first_len;
      cur_line <= '0;
      req      <= !start_empty;
      done     <= start_empty;
    end else if (req && gnt) begin
      req_addr <= nxt_addr_w[AW-1:0];
      pos_q    <= nxt_pos;
      req_len  <= nxt_len;
      if (seg_end) cur_line <= cur_line + 1'b1;
      if (nxt_done) begin
        req  <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_scan_addr.sv
module ovl_scan_addr #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int LCW         = 12,
  parameter int WORD_BYTES  = 4,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic [AW-1:0]  cfg_start_addr,
  input  logic [AW-1:0]  cfg_end_addr,
  input  logic [LW-1:0]  cfg_line_bytes,
  input  logic [LW-1:0]  cfg_skip_bytes,
  input  logic [2:0]     cfg_pix_fmt,
  input  logic           gnt,
  output logic           req,
  output logic [AW-1:0]  req_addr,
  output logic [LW-1:0]  req_len,
  output logic           done,
  output logic [LCW-1:0] cur_line
);
  logic [LW-1:0] burst_bytes;

  ovl_burst_sel #(
    .LW          (LW),
    .WORD_BYTES  (WORD_BYTES),
    .SHORT_WORDS (SHORT_WORDS),
    .LONG_WORDS  (LONG_WORDS)
  ) u_burst_sel (
    .fmt         (cfg_pix_fmt),
    .burst_bytes (burst_bytes)
  );

  ovl_line_walker #(
    .AW  (AW),
    .LW  (LW),
    .LCW (LCW)
  ) u_walker (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .gnt         (gnt),
    .cfg_start   (cfg_start_addr),
    .cfg_end     (cfg_end_addr),
    .cfg_line    (cfg_line_bytes),
    .cfg_skip    (cfg_skip_bytes),
    .burst_in    (burst_bytes),
    .req         (req),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .done        (done),
    .cur_line    (cur_line)
  );
endmodule

// File: rtl/ovl_scan_addr_chk.sv
module ovl_scan_addr_chk #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int LCW         = 12,
  parameter int WORD_BYTES  = 4,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_start,
  input logic [AW-1:0]  cfg_start_addr,
  input logic           gnt,
  input logic           req,
  input logic [AW-1:0]  req_addr,
  input logic [LW-1:0]  req_len,
  input logic           done,
  input logic [LCW-1:0] cur_line
);
  localparam int MAX_WORDS = (LONG_WORDS > SHORT_WORDS) ? LONG_WORDS : SHORT_WORDS;
  localparam logic [LW-1:0] MAX_B = LW'(MAX_WORDS * WORD_BYTES);

  p_fs_load_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (req_addr == $past(cfg_start_addr)) && (cur_line == '0));

  p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
    req |-> (req_len != '0) && (req_len <= MAX_B));

  p_addr_adv_r5: assert property (@(posedge clk) disable iff (rst)
    (req && gnt && !frame_start) |=> (req_addr > $past(req_addr)));

  p_line_step_r6: assert property (@(posedge clk) disable iff (rst)
    (req && gnt && !frame_start) |=>
      (cur_line == $past(cur_line)) || (cur_line == LCW'($past(cur_line) + 1'b1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req && !gnt && !frame_start) |=> req && $stable(req_addr) && $stable(req_len));

  p_done_noreq_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !frame_start) |=> done && $stable(req_addr));
endmodule

bind ovl_scan_addr ovl_scan_addr_chk #(
  .AW          (AW),
  .LW          (LW),
  .LCW         (LCW),
  .WORD_BYTES  (WORD_BYTES),
  .SHORT_WORDS (SHORT_WORDS),
  .LONG_WORDS  (LONG_WORDS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_start    (frame_start),
  .cfg_start_addr (cfg_start_addr),
  .gnt            (gnt),
  .req            (req),
  .req_addr       (req_addr),
  .req_len        (req_len),
  .done           (done),
  .cur_line       (cur_line)
);

// File: tb/ovl_scan_addr_bench.sv
module ovl_scan_addr_bench;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int LCW = 12;

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] endv;
    logic [15:0] line;
    logic [15:0] skip;
    logic [2:0]  fmt;
    logic [15:0] burst;
    logic [15:0] nreq;
    logic [15:0] lines;
  } vec_t;

  localparam int NV = 7;
  // start, end, line bytes, skip, fmt, expected burst bytes, expected requests, expected lines
  localparam vec_t VEC [NV] = '{
    '{32'h1000, 32'h1300, 16'd160, 16'd96, 3'd3, 16'd64, 16'd9, 16'd3},
    '{32'h2000, 32'h2080, 16'd64,  16'd0,  3'd0, 16'd32, 16'd4, 16'd2},
    '{32'h4010, 32'h4110, 16'd100, 16'd28, 3'd7, 16'd64, 16'd4, 16'd2},
    '{32'h0800, 32'h0900, 16'd24,  16'd40, 3'd1, 16'd64, 16'd4, 16'd4},
    '{32'h3000, 32'h3080, 16'd128, 16'd0,  3'd2, 16'd64, 16'd2, 16'd1},
    '{32'h5000, 32'h5040, 16'd64,  16'd0,  3'd4, 16'd64, 16'd1, 16'd1},
    '{32'h6000, 32'h6100, 16'd96,  16'd32, 3'd5, 16'd64, 16'd4, 16'd2}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           frame_start = 1'b0;
  logic [AW-1:0]  cfg_start_addr = '0;
  logic [AW-1:0]  cfg_end_addr = '0;
  logic [LW-1:0]  cfg_line_bytes = '0;
  logic [LW-1:0]  cfg_skip_bytes = '0;
  logic [2:0]     cfg_pix_fmt = '0;
  logic           gnt = 1'b0;
  logic           req;
  logic [AW-1:0]  req_addr;
  logic [LW-1:0]  req_len;
  logic           done;
  logic [LCW-1:0] cur_line;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ovl_scan_addr u_ovl_scan_addr (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .cfg_start_addr (cfg_start_addr),
    .cfg_end_addr   (cfg_end_addr),
    .cfg_line_bytes (cfg_line_bytes),
    .cfg_skip_bytes (cfg_skip_bytes),
    .cfg_pix_fmt    (cfg_pix_fmt),
    .gnt            (gnt),
    .req            (req),
    .req_addr       (req_addr),
    .req_len        (req_len),
    .done           (done),
    .cur_line       (cur_line)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input vec_t v);
    cfg_start_addr = v.start;
    cfg_end_addr   = v.endv;
    cfg_line_bytes = v.line;
    cfg_skip_bytes = v.skip;
    cfg_pix_fmt    = v.fmt;
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic grant_once();
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req == 1'b0, "R1 req", req, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(req_addr == '0, "R1 addr", req_addr, 0);
    chk(cur_line == '0, "R1 line", cur_line, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      longint ea;
      longint ep;
      longint el;
      int n;
      load_cfg(VEC[i]);
      pulse_frame();
      chk(req == 1'b1 && done == 1'b0, "R2 req after frame start", {req, done}, 2'b10);
      chk(req_addr == VEC[i].start, "R2 start addr", req_addr, VEC[i].start);
      chk(cur_line == '0, "R2 line cleared", cur_line, 0);
      chk(req_len == ((VEC[i].line < VEC[i].burst) ? VEC[i].line : VEC[i].burst),
          "R3 first burst", req_len, VEC[i].burst);
      ea = VEC[i].start; ep = 0; el = 0; n = 0;
      while (req && n < 64) begin
        longint rem;
        longint elen;
        rem  = VEC[i].line - ep;
        elen = (rem < VEC[i].burst) ? rem : VEC[i].burst;
        chk(req_addr == ea[AW-1:0], "R5/R6 addr", req_addr, ea);
        chk(req_len == elen[LW-1:0], "R4 len", req_len, elen);
        chk(cur_line == el[LCW-1:0], "R6 line index", cur_line, el);
        for (int w = 0; w < (n + i) % 3; w++) begin
          @(negedge clk);
          chk(req == 1'b1 && req_addr == ea[AW-1:0] && req_len == elen[LW-1:0],
              "R7 hold without grant", req_addr, ea);
        end
        grant_once();
        n++;
        if (ep + elen >= VEC[i].line) begin
          ea = ea + elen + VEC[i].skip; ep = 0; el++;
        end else begin
          ea = ea + elen; ep = ep + elen;
        end
      end
      chk(n == int'(VEC[i].nreq), "R8 request count", n, VEC[i].nreq);
      chk(done == 1'b1 && req == 1'b0, "R8 done raised", {done, req}, 2'b10);
      chk(cur_line == VEC[i].lines[LCW-1:0], "R6 final line count", cur_line, VEC[i].lines);
    end

    // R8: grant after done has no effect
    begin
      logic [AW-1:0] held;
      held = req_addr;
      gnt = 1'b1;
      repeat (2) @(negedge clk);
      gnt = 1'b0;
      chk(req_addr == held && done && !req, "R8 grant ignored after done", req_addr, held);
    end

    // R9: zero line size
    load_cfg(VEC[0]);
    cfg_line_bytes = '0;
    pulse_frame();
    chk(done == 1'b1 && req == 1'b0, "R9 zero line", {done, req}, 2'b10);
    // R9: start equals end
    load_cfg(VEC[1]);
    cfg_end_addr = VEC[1].start;
    pulse_frame();
    chk(done == 1'b1 && req == 1'b0, "R9 empty range", {done, req}, 2'b10);

    // R11: restart mid-frame
    load_cfg(VEC[3]);
    pulse_frame();
    grant_once();
    grant_once();
    chk(cur_line == 12'd2, "R11 progressed before restart", cur_line, 2);
    pulse_frame();
    chk(req_addr == VEC[3].start && cur_line == '0 && req && !done,
        "R11 restart", req_addr, VEC[3].start);

    // R10: configuration changes mid-frame are ignored
    load_cfg(VEC[1]);
    pulse_frame();
    cfg_line_bytes = 16'd16;
    cfg_skip_bytes = 16'd200;
    cfg_pix_fmt    = 3'd3;
    cfg_end_addr   = 32'h0000_ffff;
    cfg_start_addr = 32'h0000_9000;
    grant_once();
    chk(req_addr == VEC[1].start + 32 && req_len == 16'd32, "R10 first step", req_addr, VEC[1].start + 32);
    grant_once();
    chk(req_addr == VEC[1].start + 64 && cur_line == 12'd1, "R10 line end", req_addr, VEC[1].start + 64);
    grant_once();
    grant_once();
    chk(done == 1'b1 && req == 1'b0, "R10 end kept", {done, req}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule